// File: doc/BRIEF.md
# Address-Triggered SPI Flash Chip-Select Router

This block sits beside a single-lane SPI flash bus and listens to it without driving any of the shared wires. Clock, MOSI and MISO stay wired in common to two flash devices, a primary and an alternate. Only chip-select is routed. The block samples the host's SCK, MOSI and CS_n with a faster system clock and decodes every read command together with its 24-bit address.

Two inclusive address windows are supplied as configuration inputs. A read whose address lands in the arm window switches later transactions to the alternate device. A read whose address lands in the disarm window switches them back to the primary device. The disarm window is meant to cover addresses that a normal boot never fetches, so the block cannot drop back to the primary device by accident.

The routing decision is held as state and changes only between transactions. No single transaction is ever split across the two devices.

Top module: `spi_cs_router`

## Requirements
- R1: After reset `altActive` is 0. `primaryCsN` follows `hostCsN`, and `altCsN` stays 1.
- R2: A read transaction has these parts, all sampled on rising SCK while `hostCsN` is low: command byte 0x03, then a 24-bit address, MSB first. If its address lies in [`armLo`,`armHi`], the transactions that follow go to the alternate device and `altActive` becomes 1.
- R3: A routing change takes effect only after `hostCsN` has returned high. During the transaction that caused the change, chip-select stays on the device that was selected when the transaction began.
- R4: A read whose address lies in [`disLo`,`disHi`] returns the transactions that follow to the primary device and clears `altActive`.
- R5: While the alternate device is selected, `primaryCsN` is held at 1 and `altCsN` follows `hostCsN`. While the primary device is selected, the opposite holds.
- R6: A command byte other than 0x03 never changes the routing, even when the 24 bits after it hold an address inside a window.
- R7: A transaction that ends before 32 bits have been clocked never changes the routing. Bits clocked after the 32nd are ignored.
- R8: If a read address lies in both windows, disarm takes priority and the primary device is selected.
- R9: Window bounds are inclusive. A window with low bound greater than high bound matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, several times faster than SCK |
| rstN | input | 1 | Active-low synchronous reset |
| hostSck | input | 1 | SPI clock from the host (observed only) |
| hostMosi | input | 1 | SPI data from the host (observed only) |
| hostCsN | input | 1 | Host chip-select, active low |
| armLo | input | 24 | Arm window low bound, inclusive |
| armHi | input | 24 | Arm window high bound, inclusive |
| disLo | input | 24 | Disarm window low bound, inclusive |
| disHi | input | 24 | Disarm window high bound, inclusive |
| primaryCsN | output | 1 | Chip-select to the primary flash device |
| altCsN | output | 1 | Chip-select to the alternate flash device |
| altActive | output | 1 | 1 while transactions are routed to the alternate device |

## Verification
The hardest case to reach from the ports is the cycle in which an arming or disarming read has been decoded but the host still holds CS_n low. Here the new decision must already be pending while the current chip-select stays where it was. The bench checks both chip-select outputs at the end of each triggering transaction, just before it raises `hostCsN`, and checks them again once `hostCsN` is high. Partial frames, overlong frames and the overlapping-window case are generated by the same transaction task, which takes a bit count and a command byte as arguments.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Event strobes sent from the snooping datapath to the routing control
  typedef struct packed {
    logic hitArm;     // completed read landed in the arm window
    logic hitDisarm;  // completed read landed in the disarm window
    logic txnEnd;     // synchronised host chip-select has just gone high
  } snoopEv_t;
endpackage

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CMD_W       = 8,
  parameter logic [CMD_W-1:0] READ_CMD = 8'h03,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSck,
  input  logic              hostMosi,
  input  logic              hostCsN,
  input  logic [ADDR_W-1:0] armLo,
  input  logic [ADDR_W-1:0] armHi,
  input  logic [ADDR_W-1:0] disLo,
  input  logic [ADDR_W-1:0] disHi,
  output snoopEv_t          ev
);
  localparam int FRAME_W = CMD_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [2:0] SYNC_RST = 3'b001;  // {sck, mosi, csN}
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [2:0] rawIn;
  logic [2:0] syncQ [SYNC_STAGES];
  assign rawIn = {hostSck, hostMosi, hostCsN};

  // Synchroniser chain, one stage per parameter step
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= SYNC_RST;
        else       syncQ[g] <= rawIn;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[g] <= SYNC_RST;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic sckS, mosiS, csS, sckD, csD;
  assign {sckS, mosiS, csS} = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckD <= 1'b0;
      csD  <= 1'b1;
    end else begin
      sckD <= sckS;
      csD  <= csS;
    end
  end

  logic sckRise, csRise;
  assign sckRise = sckS & ~sckD;
  assign csRise  = csS & ~csD;

  logic [FRAME_W-1:0] shiftQ, frameNext;
  logic [CNT_W-1:0]   bitCnt;
  assign frameNext = {shiftQ[FRAME_W-2:0], mosiS};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sckRise && bitCnt != FULL_CNT) begin
      shiftQ <= frameNext;
      bitCnt <= bitCnt + 1'b1;
    end
  end

  function automatic logic inWindow(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic              lastBit, isRead;
  logic [ADDR_W-1:0] addrNext;
  assign lastBit  = !csS && sckRise && (bitCnt == LAST_IDX);
  assign isRead   = frameNext[FRAME_W-1 -: CMD_W] == READ_CMD;
  assign addrNext = frameNext[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ev <= '0;
    end else begin
      ev.hitArm    <= lastBit && isRead && inWindow(addrNext, armLo, armHi);
      ev.hitDisarm <= lastBit && isRead && inWindow(addrNext, disLo, disHi);
      ev.txnEnd    <= csRise;
    end
  end

  // R7: the bit counter never runs past one full frame
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);
  // R3: decode strobes and end-of-transaction strobes never coincide
  a_r3_hit_not_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !(ev.txnEnd && (ev.hitArm || ev.hitDisarm)));
endmodule

// File: rtl/csr_control.sv
module csr_control
  import csr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  snoopEv_t ev,
  output logic     routeAlt
);
  logic pendRoute;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRoute <= 1'b0;
      routeAlt  <= 1'b0;
    end else begin
      if (ev.hitDisarm)   pendRoute <= 1'b0;  // disarm outranks arm
      else if (ev.hitArm) pendRoute <= 1'b1;
      if (ev.txnEnd)      routeAlt  <= pendRoute;
    end
  end

  // R3: the applied route moves only on the cycle after a transaction end
  a_r3_change_at_end: assert property (@(posedge clk) disable iff (!rstN)
    (routeAlt != $past(routeAlt)) |-> $past(ev.txnEnd));
  // R8: a disarm hit always leaves the pending decision on the primary device
  a_r8_disarm_priority: assert property (@(posedge clk) disable iff (!rstN)
    ev.hitDisarm |=> !pendRoute);
  // R2: an arm-only hit always leaves the alternate device pending
  a_r2_arm_pending: assert property (@(posedge clk) disable iff (!rstN)
    (ev.hitArm && !ev.hitDisarm) |=> pendRoute);
endmodule

// File: rtl/spi_cs_router.sv
module spi_cs_router
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CMD_W       = 8,
  parameter logic [CMD_W-1:0] READ_CMD = 8'h03,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSck,
  input  logic              hostMosi,
  input  logic              hostCsN,
  input  logic [ADDR_W-1:0] armLo,
  input  logic [ADDR_W-1:0] armHi,
  input  logic [ADDR_W-1:0] disLo,
  input  logic [ADDR_W-1:0] disHi,
  output logic              primaryCsN,
  output logic              altCsN,
  output logic              altActive
);
  snoopEv_t ev;
  logic     routeAlt;

  csr_datapath #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .READ_CMD(READ_CMD), .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .hostSck(hostSck), .hostMosi(hostMosi),
    .hostCsN(hostCsN), .armLo(armLo), .armHi(armHi), .disLo(disLo),
    .disHi(disHi), .ev(ev)
  );

  csr_control uControl (.clk(clk), .rstN(rstN), .ev(ev), .routeAlt(routeAlt));

  // Raw host chip-select is steered so the flash sees no added latency
  assign primaryCsN = hostCsN | routeAlt;
  assign altCsN     = hostCsN | ~routeAlt;
  assign altActive  = routeAlt;

  // R1: reset leaves the primary device selected
  a_r1_reset_primary: assert property (@(posedge clk)
    $past(!rstN) |-> !altActive);
endmodule

// File: tb/tb_spi_cs_router.sv
module tb_spi_cs_router;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 30;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostSck = 1'b0, hostMosi = 1'b0, hostCsN = 1'b1;
  logic [23:0] armLo, armHi, disLo, disHi;
  logic primaryCsN, altCsN, altActive;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_router dut (
    .clk(clk), .rstN(rstN), .hostSck(hostSck), .hostMosi(hostMosi),
    .hostCsN(hostCsN), .armLo(armLo), .armHi(armHi), .disLo(disLo),
    .disHi(disHi), .primaryCsN(primaryCsN), .altCsN(altCsN), .altActive(altActive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one transaction; expBefore is the route in force, expAfter the route after
  task automatic sendTxn(input string tag, input logic [7:0] cmd, input logic [23:0] addr,
                         input int nbits, input bit expBefore, input bit expAfter);
    logic [31:0] word;
    word = {cmd, addr};
    @(negedge clk);
    hostCsN = 1'b0;
    #(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      hostMosi = (i < 32) ? word[31-i] : 1'b0;
      #(HALF_SCK) hostSck = 1'b1;
      #(HALF_SCK) hostSck = 1'b0;
    end
    #(HALF_SCK);
    // R3/R5: still on the device chosen before this transaction
    check({tag, " R3 route held mid-txn"}, {31'b0, altActive}, {31'b0, expBefore});
    check({tag, " R5 primaryCsN mid-txn"}, {31'b0, primaryCsN}, {31'b0, expBefore});
    check({tag, " R5 altCsN mid-txn"}, {31'b0, altCsN}, {31'b0, !expBefore});
    hostCsN = 1'b1;
    repeat (8) @(negedge clk);
    check({tag, " route after txn"}, {31'b0, altActive}, {31'b0, expAfter});
    check({tag, " R5 both high when idle"}, {30'b0, primaryCsN, altCsN}, 32'd3);
  endtask

  // Vector: {cmd, addr, nbits, expected route after}
  localparam int NVEC = 10;
  localparam logic [40:0] VEC [NVEC] = '{
    {8'h03, 24'h000100, 8'd32, 1'b0},  // outside both windows
    {8'h03, 24'h0FFFFF, 8'd32, 1'b0},  // R9 one below arm low bound
    {8'h0B, 24'h100010, 8'd32, 1'b0},  // R6 other command ignored
    {8'h03, 24'h100010, 8'd20, 1'b0},  // R7 short frame ignored
    {8'h03, 24'h100000, 8'd32, 1'b1},  // R2 arm at low bound
    {8'h03, 24'h200000, 8'd32, 1'b1},  // stays armed
    {8'h03, 24'hFFEFFF, 8'd32, 1'b1},  // R9 one below disarm low bound
    {8'h03, 24'hFFF000, 8'd32, 1'b0},  // R4 disarm at low bound
    {8'h03, 24'h1000FF, 8'd40, 1'b1},  // R2 arm at high bound, R7 extra bits
    {8'h03, 24'hFFFFFF, 8'd32, 1'b0}   // R4 disarm at high bound
  };

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit prev;
    armLo = 24'h100000; armHi = 24'h1000FF;
    disLo = 24'hFFF000; disHi = 24'hFFFFFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset altActive", {31'b0, altActive}, 32'd0);
    check("R1 reset altCsN", {31'b0, altCsN}, 32'd1);
    hostCsN = 1'b0; #1;
    check("R1 primary follows host", {31'b0, primaryCsN}, 32'd0);
    hostCsN = 1'b1;
    repeat (6) @(negedge clk);

    prev = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      sendTxn($sformatf("vec%0d", v), VEC[v][40:33], VEC[v][32:9],
              int'(VEC[v][8:1]), prev, VEC[v][0]);
      prev = VEC[v][0];
    end

    // R8: overlapping windows, disarm wins
    armLo = 24'h300000; armHi = 24'h3000FF;
    disLo = 24'h300080; disHi = 24'h3000FF;
    sendTxn("R8 arm in overlap setup", 8'h03, 24'h300010, 32, 1'b0, 1'b1);
    sendTxn("R8 both windows", 8'h03, 24'h300090, 32, 1'b1, 1'b0);

    // R9: empty arm window never matches
    armLo = 24'h500000; armHi = 24'h4FFFFF;
    sendTxn("R9 empty window", 8'h03, 24'h500000, 32, 1'b0, 1'b0);

    // R1: reset from the armed state returns to primary
    armLo = 24'h600000; armHi = 24'h600000;
    sendTxn("R2 single-address window", 8'h03, 24'h600000, 32, 1'b0, 1'b1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset from armed", {31'b0, altActive}, 32'd0);
    check("R1 altCsN high after reset", {31'b0, altCsN}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule